// File: doc/BRIEF.md
# Asynchronous SRAM Write-Cycle Sequencer

This block turns single write requests from a clocked system into properly timed write cycles on an external asynchronous static RAM of 16K bytes. The RAM is organised as 128 rows by 128 columns of 8-bit words, so a request carries a 14-bit address and one data byte. The request is accepted over a valid/ready handshake. The block then drives the RAM's address lines, the data lines with their own output enable, an active-low chip select and an active-low write strobe.

Each timing interval of the write cycle is an integer clock-cycle parameter:
- address setup before the strobe falls (`T_AS`)
- strobe low width (`T_W`)
- data setup before the strobe rises (`T_DS`)
- data hold after the rise (`T_DH`)
- address hold after the rise (`T_AH`)
- minimum total cycle time (`T_WC`)

From these the block derives a strobe lead, a data-drive window and a total cycle length, so every interval is met with whole clock periods. When the data setup is longer than the strobe width, the strobe fall is pushed later and the data is presented before the fall.

All outputs come straight from registers, so the RAM pins carry no combinational glitches. Software and read traffic are handled elsewhere. The block only sequences writes, one at a time.

Top module: `sram_wr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `sram_cs_n`=1, `sram_we_n`=1, `sram_dq_oe`=0, `wr_done`=0 and `req_ready`=1, whatever cycle was in progress.
- R2: A request is taken at an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 in every cycle in which `sram_cs_n` is 0. Request inputs presented while busy have no effect on the cycle in progress.
- R3: In the cycle after acceptance (index 0), `sram_cs_n` goes to 0 and `sram_addr` shows the accepted address. The address stays unchanged for every cycle with `sram_cs_n`=0.
- R4: `sram_we_n` is 0 exactly in the cycles with index from LEAD to LEAD+`T_W`-1, where LEAD = max(`T_AS`, `T_DS`-`T_W`). Index 0 is the first chip-select cycle.
- R5: Each strobe low pulse lasts exactly `T_W` cycles.
- R6: `sram_dq_oe` is 1 exactly in the cycles with index from LEAD+`T_W`-`T_DS` to LEAD+`T_W`+`T_DH`-1. While it is 1, `sram_dq_out` equals the accepted byte.
- R7: `sram_cs_n` stays 0 for exactly CYC cycles, where CYC = max(`T_WC`, LEAD+`T_W`+max(`T_DH`,`T_AH`)). This keeps the address valid for at least `T_AH` cycles after the strobe rises.
- R8: `wr_done` is 1 for exactly one cycle: the first cycle after the last chip-select cycle, which is also the first cycle in which `req_ready` is 1 again.
- R9: Outside a write cycle, `sram_we_n`=1 and `sram_dq_oe`=0. The strobe is never 0 while `sram_cs_n` is 1.
- R10: A RAM that stores the driven byte at the strobe's rising edge ends up holding, for every address, the byte of the last write that completed to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Target word address |
| req_data | input | DATA_W | Byte to write |
| sram_addr | output | ADDR_W | RAM address lines |
| sram_dq_out | output | DATA_W | Value for the RAM data lines |
| sram_dq_oe | output | 1 | Enable for the data line drivers |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| wr_done | output | 1 | One-cycle pulse at the end of a write cycle |

## Verification
A wrong cycle count or phase shows at the ports within the same write cycle. The strobe or the data enable then moves off its expected index, or the chip-select run comes out longer or shorter than CYC. The bench catches this on the cycle where the edge lands. A corrupted address or data register shows as a mismatch on `sram_addr` or `sram_dq_out` in the next chip-select cycle. It also leaves a wrong byte in the modelled RAM, which the final sweep over all 16K words exposes. A stuck busy flag appears as `req_ready` staying low past the cycle that should carry `wr_done`.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // cycles from first chip-select cycle to strobe fall
    function automatic int strobe_lead(input int t_as, input int t_w, input int t_ds);
        return imax(t_as, t_ds - t_w);
    endfunction

    // total chip-select cycles
    function automatic int cycle_len(input int t_as, input int t_w, input int t_ds,
                                     input int t_dh, input int t_ah, input int t_wc);
        return imax(t_wc, strobe_lead(t_as, t_w, t_ds) + t_w + imax(t_dh, t_ah));
    endfunction

endpackage

// File: rtl/sram_wr_window.sv
module sram_wr_window #(
    parameter int W  = 4,
    parameter int LO = 0,
    parameter int HI = 1
) (
    input  logic [W-1:0] idx,
    output logic         hit
);
    generate
        if (LO == 0) begin : g_from_zero
            assign hit = (idx < W'(HI));
        end else begin : g_from_lo
            assign hit = (idx >= W'(LO)) && (idx < W'(HI));
        end
    endgenerate
endmodule

// File: rtl/sram_wr_index.sv
module sram_wr_index #(
    parameter int W    = 4,
    parameter int LAST = 1
) (
    input  logic         busy,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] idx,
    output logic         at_last
);
    // index of the cycle that follows: zero when a new cycle would start
    assign idx     = busy ? (cnt + 1'b1) : '0;
    assign at_last = busy && (cnt == W'(LAST));
endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
    import sram_wr_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8,
    parameter int T_AS   = 2,
    parameter int T_W    = 3,
    parameter int T_DS   = 4,
    parameter int T_DH   = 2,
    parameter int T_AH   = 1,
    parameter int T_WC   = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic              wr_done
);
    localparam int LEAD   = strobe_lead(T_AS, T_W, T_DS);
    localparam int RISE   = LEAD + T_W;
    localparam int DRV_LO = RISE - T_DS;
    localparam int DRV_HI = RISE + T_DH;
    localparam int CYC    = cycle_len(T_AS, T_W, T_DS, T_DH, T_AH, T_WC);
    localparam int CNT_W  = $clog2(CYC + 1);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              oe;
        logic              cs_n;
        logic              we_n;
        logic              done;
    } seq_t;

    localparam seq_t IDLE_S = '{busy: 1'b0, cnt: '0, addr: '0, data: '0,
                                oe: 1'b0, cs_n: 1'b1, we_n: 1'b1, done: 1'b0};

    seq_t q, d;

    logic [CNT_W-1:0] idx;
    logic             at_last;
    logic             strobe_hit;
    logic             drive_hit;

    sram_wr_index #(.W(CNT_W), .LAST(CYC - 1)) i_index (
        .busy    (q.busy),
        .cnt     (q.cnt),
        .idx     (idx),
        .at_last (at_last)
    );

    sram_wr_window #(.W(CNT_W), .LO(LEAD), .HI(RISE)) i_strobe_win (
        .idx (idx),
        .hit (strobe_hit)
    );

    sram_wr_window #(.W(CNT_W), .LO(DRV_LO), .HI(DRV_HI)) i_drive_win (
        .idx (idx),
        .hit (drive_hit)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (req_valid) begin
                d.busy = 1'b1;
                d.cnt  = '0;
                d.addr = req_addr;
                d.data = req_data;
                d.cs_n = 1'b0;
                d.we_n = ~strobe_hit;
                d.oe   = drive_hit;
            end
        end else if (at_last) begin
            d      = IDLE_S;
            d.addr = q.addr;
            d.data = q.data;
            d.done = 1'b1;
        end else begin
            d.cnt  = idx;
            d.we_n = ~strobe_hit;
            d.oe   = drive_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= IDLE_S;
        else     q <= d;
    end

    assign req_ready   = ~q.busy;
    assign sram_addr   = q.addr;
    assign sram_dq_out = q.data;
    assign sram_dq_oe  = q.oe;
    assign sram_cs_n   = q.cs_n;
    assign sram_we_n   = q.we_n;
    assign wr_done     = q.done;
endmodule

// File: rtl/sram_wr_chk.sv
module sram_wr_chk #(
    parameter int ADDR_W = 14,
    parameter int T_W    = 3,
    parameter int T_DS   = 4,
    parameter int T_DH   = 2,
    parameter int T_AH   = 1,
    parameter int T_WC   = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_dq_oe,
    input logic              sram_cs_n,
    input logic              sram_we_n,
    input logic              wr_done
);
    logic [15:0] we_run_q, oe_run_q, cs_run_q, after_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_run_q <= '0;
            oe_run_q <= '0;
            cs_run_q <= '0;
            after_q  <= '0;
        end else begin
            we_run_q <= sram_we_n  ? 16'd0 : (we_run_q == 16'hFFFF ? we_run_q : we_run_q + 16'd1);
            oe_run_q <= !sram_dq_oe ? 16'd0 : (oe_run_q == 16'hFFFF ? oe_run_q : oe_run_q + 16'd1);
            cs_run_q <= sram_cs_n  ? 16'd0 : (cs_run_q == 16'hFFFF ? cs_run_q : cs_run_q + 16'd1);
            after_q  <= (sram_cs_n || !sram_we_n || we_run_q == 16'd0 && after_q == 16'd0) ? 16'd0
                        : (after_q == 16'hFFFF ? after_q : after_q + 16'd1);
        end
    end

    assert_we_needs_cs_R9: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> !sram_cs_n);

    assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (rst)
        !sram_cs_n |-> !req_ready);

    assert_addr_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

    assert_pulse_width_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> (we_run_q == 16'(T_W)));

    assert_data_setup_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> (sram_dq_oe && oe_run_q >= 16'(T_DS)));

    assert_data_hold_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(sram_dq_oe) |-> (after_q >= 16'(T_DH)));

    assert_cycle_len_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_cs_n) |-> (cs_run_q >= 16'(T_WC) && after_q >= 16'(T_AH)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        wr_done |=> !wr_done);
endmodule

bind sram_wr_seq sram_wr_chk #(
    .ADDR_W (ADDR_W),
    .T_W    (T_W),
    .T_DS   (T_DS),
    .T_DH   (T_DH),
    .T_AH   (T_AH),
    .T_WC   (T_WC)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .sram_addr  (sram_addr),
    .sram_dq_oe (sram_dq_oe),
    .sram_cs_n  (sram_cs_n),
    .sram_we_n  (sram_we_n),
    .wr_done    (wr_done)
);

// File: tb/test_sram_wr_seq.sv
`timescale 1ns/1ps
module test_sram_wr_seq;
    localparam int AW = 14, DW = 8;
    localparam int P_AS = 2, P_W = 3, P_DS = 4, P_DH = 2, P_AH = 1, P_WC = 9;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_ready;
    logic [AW-1:0] req_addr = '0, sram_addr;
    logic [DW-1:0] req_data = '0, sram_dq_out;
    logic sram_dq_oe, sram_cs_n, sram_we_n, wr_done;

    always #5 clk = ~clk;

    sram_wr_seq #(.ADDR_W(AW), .DATA_W(DW), .T_AS(P_AS), .T_W(P_W), .T_DS(P_DS),
                  .T_DH(P_DH), .T_AH(P_AH), .T_WC(P_WC)) i_sram_wr_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .sram_addr(sram_addr),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_cs_n(sram_cs_n),
        .sram_we_n(sram_we_n), .wr_done(wr_done));

    // expected timing from the requirements
    function automatic int mx(input int a, input int b); return a > b ? a : b; endfunction
    function automatic int e_lead();  return mx(P_AS, P_DS - P_W); endfunction
    function automatic int e_rise();  return e_lead() + P_W; endfunction
    function automatic int e_dlo();   return e_rise() - P_DS; endfunction
    function automatic int e_dhi();   return e_rise() + P_DH; endfunction
    function automatic int e_cyc();   return mx(P_WC, e_rise() + mx(P_DH, P_AH)); endfunction

    int n_chk = 0, n_bad = 0;
    logic [AW-1:0] exp_addr = '0;
    logic [DW-1:0] exp_data = '0;
    logic [DW-1:0] ram [1<<AW];
    logic [DW-1:0] ref_ram [1<<AW];
    int k = 0;
    bit prev_act = 1'b0, prev_we_low = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // per-cycle monitor and behavioural RAM
    always @(negedge clk) begin
        if (rst) begin
            prev_act = 1'b0;
            prev_we_low = 1'b0;
        end else if (!sram_cs_n) begin
            k = prev_act ? k + 1 : 0;
            chk(k < e_cyc(), "R7 chip select run length", k, e_cyc() - 1);
            chk(sram_addr == exp_addr, "R3 address", sram_addr, exp_addr);
            chk(sram_we_n == !(k >= e_lead() && k < e_rise()), "R4 R5 strobe phase", sram_we_n,
                !(k >= e_lead() && k < e_rise()));
            chk(sram_dq_oe == (k >= e_dlo() && k < e_dhi()), "R6 data enable window", sram_dq_oe,
                (k >= e_dlo() && k < e_dhi()));
            if (sram_dq_oe) chk(sram_dq_out == exp_data, "R6 data value", sram_dq_out, exp_data);
            chk(!req_ready, "R2 ready low while busy", req_ready, 0);
            chk(!wr_done, "R8 no done mid cycle", wr_done, 0);
            if (prev_we_low && sram_we_n && sram_dq_oe) ram[sram_addr] = sram_dq_out;
            prev_act = 1'b1;
            prev_we_low = !sram_we_n;
        end else begin
            chk(sram_we_n && !sram_dq_oe, "R9 idle strobe and bus", {sram_we_n, sram_dq_oe}, 2'b10);
            chk(req_ready, "R2 ready when idle", req_ready, 1);
            chk(wr_done == prev_act, "R8 done pulse", wr_done, prev_act);
            if (prev_act) chk(k == e_cyc() - 1, "R7 cycle length", k + 1, e_cyc());
            prev_act = 1'b0;
            prev_we_low = 1'b0;
        end
    end

    // called at a falling edge
    task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] dv, input bit record);
        req_valid = 1'b1; req_addr = a; req_data = dv;
        while (!req_ready) @(negedge clk);
        exp_addr = a; exp_data = dv;
        if (record) ref_ram[a] = dv;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'h5A17));
        for (int i = 0; i < (1 << AW); i++) begin ram[i] = '0; ref_ram[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(sram_cs_n && sram_we_n && !sram_dq_oe && !wr_done && req_ready, "R1 reset state",
            {sram_cs_n, sram_we_n, sram_dq_oe, wr_done, req_ready}, 5'b11001);
        // directed corners: extreme addresses and bytes, back to back
        send(14'h3FFF, 8'hFF, 1'b1);
        send(14'h0000, 8'h00, 1'b1);
        send(14'h2AAA, 8'hA5, 1'b1);
        send(14'h0000, 8'h5A, 1'b1);
        // random traffic with inputs wiggling while busy (R2: ignored)
        for (int n = 0; n < 300; n++) begin
            send(AW'($urandom % 64 == 0 ? 14'h3FFF : $urandom), DW'($urandom), 1'b1);
            for (int g = 0; g < int'($urandom % 4); g++) begin
                req_addr = AW'($urandom); req_data = DW'($urandom);
                @(negedge clk);
            end
        end
        while (!req_ready) @(negedge clk);
        repeat (2) @(negedge clk);
        // mid-cycle reset while strobe low (R1)
        req_valid = 1'b1; req_addr = 14'h1234; req_data = 8'hC3;
        exp_addr = 14'h1234; exp_data = 8'hC3;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(!sram_we_n, "R4 strobe low before abort", sram_we_n, 0);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(sram_cs_n && sram_we_n && !sram_dq_oe && !wr_done && req_ready, "R1 reset mid cycle",
            {sram_cs_n, sram_we_n, sram_dq_oe, wr_done, req_ready}, 5'b11001);
        send(14'h0ABC, 8'h3C, 1'b1);
        while (!req_ready) @(negedge clk);
        repeat (2) @(negedge clk);
        // R10 RAM contents
        begin
            int bad = 0, first = -1;
            for (int i = 0; i < (1 << AW); i++)
                if (ram[i] !== ref_ram[i]) begin bad++; if (first < 0) first = i; end
            chk(bad == 0, "R10 RAM image", bad, 0);
            if (bad != 0) chk(1'b0, "R10 first bad word", ram[first], ref_ram[first]);
        end
        summary();
    end
endmodule